// File: doc/BRIEF.md
# Counter-Compare Watchdog Timer

This block is a watchdog that measures time on a free-running 16-bit counter. The counter is stepped by a one-cycle count enable. That enable is derived from the system clock through a selectable divider. An 8-bit compare value is held against the counter's high byte. A timeout occurs when the low byte wraps from 0xFF to 0x00 while the high byte equals the compare value. When that happens, the block raises a one-cycle reset request for the rest of the chip.

Software keeps the watchdog quiet by kicking it. A kick reloads the compare value with the current high byte plus a programmable offset. The interval from a kick to a timeout therefore depends on two things: the offset, and where the low byte stood when the kick was taken.

The block also supports:
- a lock that keeps the watchdog running until the next reset;
- a flag write that forces an immediate reset request;
- a suspend option that freezes the counter while an idle input is high.

Software reaches all of this through a small register bus with a write port and a combinational read port.

Top module: `cnt_watchdog`

## Requirements
- R1: When the watchdog is active, a reset request is raised in the cycle after a count step that takes the counter low byte from 0xFF to 0x00 while the high byte equals the compare value.
- R2: Counted in count steps from the kick, the timeout equals 256 × offset + 256 − L, where L is the low byte when the kick is taken.
- R3: A write of any data to the kick register (address 2) loads the compare value (read at address 4) with the current high byte plus the offset register (address 1), modulo 256.
- R4: A write to the flag register (address 3) with bit 0 set raises the reset request after that write's edge if the watchdog is active. The same write does nothing while the watchdog is inactive.
- R5: The watchdog is active when the enable bit (control bit 0) or the lock bit (control bit 1) is set. The lock can only be set by a write. While the lock is set, a write clearing the enable bit leaves it set.
- R6: While the watchdog is active, control writes do not change the clock-select field (control bits 4:3) or the idle-suspend bit (control bit 2).
- R7: After reset, the control register reads 0x01 (enabled, divide-by-12), and the offset, compare value and counter read 0x00. The first reset request appears 3072 clock cycles after reset is released.
- R8: While the idle-suspend bit is set and idle_in is high, the counter holds its value. With the suspend bit clear, idle_in has no effect on counting.
- R9: Clock-select code 0 steps the counter once every 12 clocks, code 1 once every 4 clocks, and codes 2 and 3 on every clock.
- R10: The reset request lasts exactly one cycle. On the edge where it rises, control, offset, compare and counter return to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 control, 1 offset, 2 kick, 3 flag |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address: 0 control, 1 offset, 4 compare, 5 counter low, 6 counter high |
| rd_data | output | 8 | Combinational read data |
| idle_in | input | 1 | Idle indication from the processor |
| wdt_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The timeout path is exercised with kicks taken at different low-byte positions and with offsets of 0 through 3, including one kick taken after the high byte has advanced. These runs separate the offset term, the 256 term and the low-byte term of the interval from one another, and they expose any error of one step at the wrap. A large offset applied on a non-zero high byte shows whether the compare sum wraps modulo 256. Rate checks on each clock-select code, and counter reads with idle_in held high under both settings of the suspend bit, show which divider is in use and whether the stall is gated.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ADDR_W = 3;
    localparam int PRE_W  = 4;

    typedef enum logic [1:0] {
        SEL_DIV12 = 2'd0,
        SEL_DIV4  = 2'd1,
        SEL_DIV1  = 2'd2,
        SEL_DIV1B = 2'd3
    } clk_sel_e;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_OFFSET = 3'd1,
        A_KICK   = 3'd2,
        A_FLAG   = 3'd3,
        A_CMP    = 3'd4,
        A_CNT_LO = 3'd5,
        A_CNT_HI = 3'd6,
        A_NONE   = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic     idle_hold;
        clk_sel_e sel;
        logic     lock;
        logic     en;
    } ctrl_t;

    localparam ctrl_t CTRL_DEFAULT = '{idle_hold: 1'b0, sel: SEL_DIV12, lock: 1'b0, en: 1'b1};

    // Terminal prescaler count (divide ratio minus one) for a select code.
    function automatic logic [PRE_W-1:0] pre_limit(clk_sel_e s);
        case (s)
            SEL_DIV12: pre_limit = PRE_W'(11);
            SEL_DIV4:  pre_limit = PRE_W'(3);
            default:   pre_limit = PRE_W'(0);
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] ctrl_to_byte(ctrl_t c);
        ctrl_to_byte = {3'b000, c.sel, c.idle_hold, c.lock, c.en};
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  logic     run,
    input  clk_sel_e sel,
    output logic     tick
);
    logic [PRE_W-1:0] pcnt;
    logic [PRE_W-1:0] limit;

    assign limit = pre_limit(sel);
    assign tick  = run && (pcnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pcnt <= '0;
        end else if (run) begin
            if (pcnt >= limit) pcnt <= '0;
            else               pcnt <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         step,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst || clear) value <= '0;
        else if (step)    value <= value + 1'b1;
    end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] cnt_hi,
    output ctrl_t             ctrl,
    output logic [BYTE_W-1:0] offset,
    output logic [BYTE_W-1:0] cmp,
    output logic              active,
    output logic              force_req
);
    logic wr_ctrl, wr_ofs, wr_kick, wr_flag;

    assign wr_ctrl   = wr_en && (wr_addr == A_CTRL);
    assign wr_ofs    = wr_en && (wr_addr == A_OFFSET);
    assign wr_kick   = wr_en && (wr_addr == A_KICK);
    assign wr_flag   = wr_en && (wr_addr == A_FLAG);
    assign active    = ctrl.en || ctrl.lock;
    assign force_req = wr_flag && wr_data[0] && active;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ctrl   <= CTRL_DEFAULT;
            offset <= '0;
            cmp    <= '0;
        end else begin
            if (wr_ctrl) begin
                if (!active) begin
                    ctrl.sel       <= clk_sel_e'(wr_data[4:3]);
                    ctrl.idle_hold <= wr_data[2];
                end
                if (!ctrl.lock) ctrl.en <= wr_data[0];
                ctrl.lock <= ctrl.lock | wr_data[1];
            end
            if (wr_ofs)  offset <= wr_data;
            if (wr_kick) cmp    <= cnt_hi + offset;
        end
    end
endmodule

// File: rtl/cnt_watchdog.sv
module cnt_watchdog
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       idle_in,
    output logic       wdt_rst_req
);
    ctrl_t             ctrl;
    logic [BYTE_W-1:0] offset, cmp, cnt_lo, cnt_hi;
    logic [CNT_W-1:0]  cnt;
    logic              active, force_req, tick, run, wrap_hit, fire;

    assign run      = !(ctrl.idle_hold && idle_in);
    assign cnt_lo   = cnt[BYTE_W-1:0];
    assign cnt_hi   = cnt[CNT_W-1:BYTE_W];
    assign wrap_hit = tick && (cnt_lo == {BYTE_W{1'b1}}) && (cnt_hi == cmp);
    assign fire     = force_req || (active && wrap_hit);

    wdt_prescaler u_pre (
        .clk(clk), .rst(rst), .clear(fire), .run(run), .sel(ctrl.sel), .tick(tick)
    );

    wdt_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .clear(fire), .step(tick), .value(cnt)
    );

    wdt_regs u_regs (
        .clk(clk), .rst(rst), .clear(fire),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cnt_hi(cnt_hi), .ctrl(ctrl), .offset(offset), .cmp(cmp),
        .active(active), .force_req(force_req)
    );

    always_ff @(posedge clk) begin
        if (rst) wdt_rst_req <= 1'b0;
        else     wdt_rst_req <= fire;
    end

    always_comb begin
        case (rd_addr)
            A_CTRL:   rd_data = ctrl_to_byte(ctrl);
            A_OFFSET: rd_data = offset;
            A_CMP:    rd_data = cmp;
            A_CNT_LO: rd_data = cnt_lo;
            A_CNT_HI: rd_data = cnt_hi;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rst_req,
    input logic              active,
    input logic              tick,
    input logic [CNT_W-1:0]  cnt,
    input logic [BYTE_W-1:0] cmp,
    input ctrl_t             ctrl,
    input logic              idle_in,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [BYTE_W-1:0] wr_data
);
    // R1
    a_r1_wrap_match_fires: assert property (@(posedge clk) disable iff (rst)
        (active && tick && cnt[BYTE_W-1:0] == 8'hFF && cnt[CNT_W-1:BYTE_W] == cmp) |=> rst_req);

    // R4
    a_r4_force_fires: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_FLAG && wr_data[0] && active) |=> rst_req);

    // R4, R5
    a_r5_inactive_silent: assert property (@(posedge clk) disable iff (rst)
        !active |=> !rst_req);

    // R5
    a_r5_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        ctrl.lock |=> (ctrl.lock || rst_req));

    // R6
    a_r6_sel_frozen: assert property (@(posedge clk) disable iff (rst)
        active |=> ($stable(ctrl.sel) || rst_req));

    // R8
    a_r8_idle_stall: assert property (@(posedge clk) disable iff (rst)
        (ctrl.idle_hold && idle_in) |=> ($stable(cnt) || rst_req));

    // R10
    a_r10_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);
endmodule

bind cnt_watchdog wdt_checker u_chk (
    .clk(clk), .rst(rst), .rst_req(wdt_rst_req), .active(active), .tick(tick),
    .cnt(cnt), .cmp(cmp), .ctrl(ctrl), .idle_in(idle_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/cnt_watchdog_test.sv
module cnt_watchdog_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 4;
    localparam int VEC_OFS  [NVEC] = '{0, 1, 3, 2};
    localparam int VEC_WAIT [NVEC] = '{5, 100, 37, 300};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       idle_in = 1'b0;
    logic       wdt_rst_req;

    int tests = 0;
    int fails = 0;
    logic saw_rst;

    cnt_watchdog uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .idle_in(idle_in), .wdt_rst_req(wdt_rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; idle_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        saw_rst = wdt_rst_req;
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output int d);
        @(negedge clk);
        rd_addr = a;
        #1;
        d = int'(rd_data);
    endtask

    task automatic rate(string tag, int cycles, int exp);
        int a, b;
        bus_rd(3'd5, a);
        repeat (cycles) @(posedge clk);
        bus_rd(3'd5, b);
        check(tag, (b - a) & 255, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int v, n, lo, hi, exp_n, cmpv;
        saw_rst = 1'b0;

        // R7: reset values
        do_reset();
        bus_rd(3'd0, v); check("R7 ctrl reset", v, 1);
        bus_rd(3'd1, v); check("R7 offset reset", v, 0);
        bus_rd(3'd4, v); check("R7 compare reset", v, 0);
        bus_rd(3'd6, v); check("R7 counter high reset", v, 0);

        // R7, R1, R10: default timeout and pulse width
        do_reset();
        n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (!wdt_rst_req && n < 5000);
        check("R7 default timeout cycles", n, 3072);
        @(posedge clk); #1;
        check("R10 pulse one cycle", int'(wdt_rst_req), 0);
        bus_rd(3'd0, v); check("R10 ctrl default after fire", v, 1);

        // R2, R3, R1: table of kick vectors at undivided rate
        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            bus_wr(3'd0, 8'h00);
            bus_wr(3'd0, 8'h10);
            bus_wr(3'd1, 8'(VEC_OFS[i]));
            repeat (VEC_WAIT[i]) @(posedge clk);
            do begin
                @(negedge clk);
                rd_addr = 3'd5; #1; lo = int'(rd_data);
                rd_addr = 3'd6; #1; hi = int'(rd_data);
            end while (lo == 255);
            wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h5A;
            @(posedge clk); #1;
            wr_addr = 3'd0; wr_data = 8'h11;
            n = 1;
            @(posedge clk); #1;
            wr_en = 1'b0;
            n = 2;
            while (!wdt_rst_req && n < 3000) begin
                @(posedge clk); #1; n++;
            end
            exp_n = 256 * VEC_OFS[i] + 256 - lo;
            check($sformatf("R2 timeout vector %0d", i), n, exp_n);
        end

        // R3: kick compare value and modulo wrap
        do_reset();
        bus_wr(3'd0, 8'h00);
        bus_wr(3'd0, 8'h10);
        bus_wr(3'd1, 8'd3);
        repeat (300) @(posedge clk);
        bus_rd(3'd6, hi);
        bus_wr(3'd2, 8'h00);
        bus_rd(3'd4, cmpv);
        check("R3 compare equals high plus offset", cmpv, (hi + 3) & 255);
        bus_wr(3'd1, 8'hFF);
        bus_rd(3'd6, hi);
        bus_wr(3'd2, 8'h00);
        bus_rd(3'd4, cmpv);
        check("R3 compare modulo 256", cmpv, (hi + 255) & 255);

        // R9: clock-select rates (disabled, so select writes take effect)
        do_reset();
        bus_wr(3'd0, 8'h00);
        rate("R9 div12 rate", 120, 10);
        bus_wr(3'd0, 8'h08);
        rate("R9 div4 rate", 40, 10);
        bus_wr(3'd0, 8'h10);
        rate("R9 div1 rate", 40, 40);
        bus_wr(3'd0, 8'h18);
        rate("R9 code3 rate", 40, 40);

        // R6: select and suspend writes ignored while active
        do_reset();
        bus_wr(3'd0, 8'h15);
        bus_rd(3'd0, v); check("R6 ctrl unchanged while active", v, 1);
        rate("R6 still div12", 120, 10);

        // R8: idle suspend
        do_reset();
        bus_wr(3'd0, 8'h00);
        bus_wr(3'd0, 8'h14);
        @(negedge clk); idle_in = 1'b1;
        rate("R8 stalled while idle", 20, 0);
        @(negedge clk); idle_in = 1'b0;
        rate("R8 runs when not idle", 20, 20);
        bus_wr(3'd0, 8'h10);
        @(negedge clk); idle_in = 1'b1;
        rate("R8 idle ignored without suspend", 20, 20);
        @(negedge clk); idle_in = 1'b0;

        // R5, R4: lock alone activates; force write
        do_reset();
        bus_wr(3'd0, 8'h02);
        bus_rd(3'd0, v); check("R5 lock set enable clear", v, 2);
        bus_wr(3'd3, 8'h01);
        check("R4 force with lock only", int'(saw_rst), 1);
        bus_rd(3'd0, v); check("R10 lock cleared by fire", v, 1);
        bus_wr(3'd0, 8'h03);
        bus_wr(3'd0, 8'h00);
        bus_rd(3'd0, v); check("R5 enable kept under lock", v, 3);

        // R4: flag write ignored while inactive, or with bit 0 clear
        do_reset();
        bus_wr(3'd3, 8'h00);
        check("R4 flag bit0 clear no fire", int'(saw_rst), 0);
        bus_wr(3'd0, 8'h00);
        bus_wr(3'd3, 8'h01);
        check("R4 force ignored when inactive", int'(saw_rst), 0);
        @(posedge clk); #1;
        check("R4 no later request", int'(wdt_rst_req), 0);
        bus_rd(3'd0, v); check("R4 ctrl untouched", v, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule